// File: doc/BRIEF.md
# Event-Driven Counting Semaphore Unit

This block takes the place of interrupt handling in a hardware task kernel. It watches a set of external event lines. Each line has a programmable entry that names a target counting semaphore, made up of a node network address and a local semaphore number, together with a unit count. When a line shows activity, the unit adds that many units to the target semaphore. If the semaphore is on this node, the unit credits its own counter. If it is on another node, the unit sends a credit message through an outbound valid/ready port, so tasks never touch the network themselves.

Tasks, through the scheduler, post wait requests against local semaphores. A wait is granted when its semaphore holds at least one unit, and each grant consumes one unit. Waits that cannot be served yet stay queued in arrival order. A counter never wraps: at its ceiling it holds its value and latches an overflow flag for that semaphore.

Top module: `esu_top`

## Requirements
- R1: After reset no grant and no outbound message is presented, `wait_ready` is 1, every overflow flag is 0 and every semaphore count is 0, so a wait posted right after reset is not granted.
- R2: A rising edge on an event line, taken after a two-flop synchronizer, credits the configured unit count to the configured semaphore exactly once. A line held high, or a falling edge, adds nothing further.
- R3: Edges caught on several lines in the same cycle are kept pending and serviced one per cycle, lowest line index first.
- R4: A wait against a semaphore with zero units stays queued. Queued waits on one semaphore are granted in arrival order, one per cycle in consecutive cycles, and each grant takes one unit. A grant shows `grant_task` and `grant_sem`.
- R5: A semaphore count saturates at its all-ones value (15 for the default 4-bit count) instead of wrapping. The same update sets that semaphore's bit of `sem_ovf`, and the bit stays set until reset.
- R6: An entry whose node address differs from `node_addr` does not credit any local semaphore. It raises `msg_valid` with `msg_node`, `msg_sem` and `msg_units` equal to the entry's fields.
- R7: While `msg_valid` is 1 and `msg_ready` is 0, the message fields stay unchanged. Edges that arrive in the meantime stay pending and are sent later in index order.
- R8: A semaphore's wait queue holds QDEPTH entries (default 4). When it is full, `wait_ready` is 0 for that semaphore and a wait posted then is discarded.
- R9: At most one grant is issued per cycle. When queued waits on several semaphores are grantable in the same cycle, the lowest semaphore number wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_addr | input | ADDR_W | Network address of this node |
| evt_in | input | NUM_EVT | Asynchronous external event lines |
| cfg_we | input | 1 | Write strobe for the per-line table |
| cfg_evt | input | EVT_W | Event line whose entry is written |
| cfg_node | input | ADDR_W | Target node address for that line |
| cfg_sem | input | SEM_W | Target semaphore number for that line |
| cfg_units | input | UNIT_W | Units credited per edge of that line |
| wait_valid | input | 1 | Wait request strobe |
| wait_sem | input | SEM_W | Local semaphore the wait targets |
| wait_task | input | TASK_W | Task identifier carried by the wait |
| wait_ready | output | 1 | Queue of `wait_sem` has room |
| grant_valid | output | 1 | A wait was granted this cycle |
| grant_sem | output | SEM_W | Semaphore of the granted wait |
| grant_task | output | TASK_W | Task of the granted wait |
| sem_ovf | output | NUM_SEM | Sticky saturation flag per semaphore |
| msg_valid | output | 1 | Outbound remote credit message valid |
| msg_ready | input | 1 | Network side accepts the message |
| msg_node | output | ADDR_W | Destination node of the credit |
| msg_sem | output | SEM_W | Destination semaphore number |
| msg_units | output | UNIT_W | Units to add at the destination |

## Verification
The hardest case to reach from the ports is an outbound message stalled by a low `msg_ready` while further edges pile up in the pending flags. To get there, the bench holds `msg_ready` low, fires one remote line, then fires another, waits many cycles, and checks that the first message has not changed. It then releases `msg_ready` and checks that both messages come out in index order. A second case that is hard to reach is two semaphores becoming grantable in the same cycle. The bench sets this up by queueing two waits on one semaphore and one wait on a lower-numbered semaphore, then firing both crediting lines together. The staggered credits then force a cycle in which the lower number must win.

// File: rtl/esu_pkg.sv
package esu_pkg;
  localparam int DEF_NUM_EVT = 4;
  localparam int DEF_NUM_SEM = 4;
  localparam int DEF_CNT_W   = 4;
  localparam int DEF_UNIT_W  = 4;
  localparam int DEF_ADDR_W  = 4;
  localparam int DEF_TASK_W  = 4;
  localparam int DEF_QDEPTH  = 4;

  typedef enum logic {
    ROUTE_LOCAL  = 1'b0,
    ROUTE_REMOTE = 1'b1
  } route_e;
endpackage

// File: rtl/esu_evt_detect.sv
module esu_evt_detect #(
  parameter int NUM_EVT = 4,
  parameter int EVT_W   = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               take,
  output logic               sel_valid,
  output logic [EVT_W-1:0]   sel_idx
);
  logic [NUM_EVT-1:0] pend_q;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_line
    logic sync1_q, sync2_q, prev_q;
    logic clr;
    assign clr = take && (sel_idx == EVT_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        sync1_q   <= 1'b0;
        sync2_q   <= 1'b0;
        prev_q    <= 1'b0;
        pend_q[g] <= 1'b0;
      end else begin
        sync1_q   <= evt_in[g];
        sync2_q   <= sync1_q;
        prev_q    <= sync2_q;
        pend_q[g] <= (pend_q[g] && !clr) || (sync2_q && !prev_q);
      end
    end

    // R7
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (pend_q[g] && !clr) |=> pend_q[g])
      else $error("pending edge lost");
  end

  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        sel_valid = 1'b1;
        sel_idx   = EVT_W'(i);
      end
    end
  end

  // R3
  sel_pending_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> (sel_valid && pend_q[sel_idx]))
    else $error("service of a line that is not pending");
endmodule

// File: rtl/esu_cfg_table.sv
module esu_cfg_table #(
  parameter int NUM_EVT = 4,
  parameter int EVT_W   = $clog2(NUM_EVT),
  parameter int ADDR_W  = 4,
  parameter int SEM_W   = 2,
  parameter int UNIT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [EVT_W-1:0]  widx,
  input  logic [ADDR_W-1:0] wnode,
  input  logic [SEM_W-1:0]  wsem,
  input  logic [UNIT_W-1:0] wunits,
  input  logic [EVT_W-1:0]  ridx,
  output logic [ADDR_W-1:0] rnode,
  output logic [SEM_W-1:0]  rsem,
  output logic [UNIT_W-1:0] runits
);
  localparam int ENT_W = ADDR_W + SEM_W + UNIT_W;

  logic [ENT_W-1:0] tbl [NUM_EVT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_EVT; i++) tbl[i] <= '0;
    end else if (we) begin
      tbl[widx] <= {wnode, wsem, wunits};
    end
  end

  assign {rnode, rsem, runits} = tbl[ridx];
endmodule

// File: rtl/esu_sem_bank.sv
module esu_sem_bank #(
  parameter int NUM_SEM = 4,
  parameter int SEM_W   = $clog2(NUM_SEM),
  parameter int CNT_W   = 4,
  parameter int UNIT_W  = 4,
  parameter int TASK_W  = 4,
  parameter int QDEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              credit_valid,
  input  logic [SEM_W-1:0]  credit_sem,
  input  logic [UNIT_W-1:0] credit_units,
  input  logic              wait_valid,
  input  logic [SEM_W-1:0]  wait_sem,
  input  logic [TASK_W-1:0] wait_task,
  output logic              wait_ready,
  output logic              grant_valid,
  output logic [SEM_W-1:0]  grant_sem,
  output logic [TASK_W-1:0] grant_task,
  output logic [NUM_SEM-1:0] sem_ovf
);
  localparam int PTR_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int FILL_W = $clog2(QDEPTH + 1);
  localparam int SUM_W  = CNT_W + UNIT_W + 1;
  localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'({CNT_W{1'b1}});

  logic [NUM_SEM-1:0] elig, pop;
  logic [TASK_W-1:0]  head [NUM_SEM];
  logic [FILL_W-1:0]  fill [NUM_SEM];
  logic [SEM_W-1:0]   pick;

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_sem
    logic [TASK_W-1:0] q_mem [QDEPTH];
    logic [PTR_W-1:0]  wp_q, rp_q;
    logic [FILL_W-1:0] fill_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              ovf_q;
    logic              push;
    logic [SUM_W-1:0]  sum;

    assign push    = wait_valid && (wait_sem == SEM_W'(g)) && (fill_q != FILL_W'(QDEPTH));
    assign elig[g] = (fill_q != '0) && (cnt_q != '0);
    assign head[g] = q_mem[rp_q];
    assign fill[g] = fill_q;
    assign sem_ovf[g] = ovf_q;

    always_comb begin
      sum = SUM_W'(cnt_q);
      if (credit_valid && (credit_sem == SEM_W'(g))) sum = sum + SUM_W'(credit_units);
      sum = sum - SUM_W'(pop[g]);
    end

    always_ff @(posedge clk) begin
      if (push) q_mem[wp_q] <= wait_task;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        wp_q   <= '0;
        rp_q   <= '0;
        fill_q <= '0;
      end else begin
        if (push) wp_q <= (wp_q == PTR_W'(QDEPTH - 1)) ? '0 : wp_q + 1'b1;
        if (pop[g]) rp_q <= (rp_q == PTR_W'(QDEPTH - 1)) ? '0 : rp_q + 1'b1;
        fill_q <= fill_q + FILL_W'(push) - FILL_W'(pop[g]);
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end else if (sum > CNT_MAX) begin
        cnt_q <= CNT_MAX[CNT_W-1:0];
        ovf_q <= 1'b1;
      end else begin
        cnt_q <= sum[CNT_W-1:0];
      end
    end

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      ovf_q |=> ovf_q)
      else $error("overflow flag cleared");

    // R8
    queue_bound_chk: assert property (@(posedge clk) disable iff (rst)
      fill_q <= FILL_W'(QDEPTH))
      else $error("wait queue overfilled");
  end

  always_comb begin
    pop  = '0;
    pick = '0;
    for (int i = NUM_SEM - 1; i >= 0; i--) begin
      if (elig[i]) begin
        pop  = '0;
        pop[i] = 1'b1;
        pick = SEM_W'(i);
      end
    end
  end

  assign wait_ready = (fill[wait_sem] != FILL_W'(QDEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_sem   <= '0;
      grant_task  <= '0;
    end else begin
      grant_valid <= |pop;
      grant_sem   <= pick;
      grant_task  <= head[pick];
    end
  end

  // R9
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pop))
    else $error("more than one grant in a cycle");
endmodule

// File: rtl/esu_top.sv
module esu_top
  import esu_pkg::*;
#(
  parameter int NUM_EVT = DEF_NUM_EVT,
  parameter int NUM_SEM = DEF_NUM_SEM,
  parameter int CNT_W   = DEF_CNT_W,
  parameter int UNIT_W  = DEF_UNIT_W,
  parameter int ADDR_W  = DEF_ADDR_W,
  parameter int TASK_W  = DEF_TASK_W,
  parameter int QDEPTH  = DEF_QDEPTH,
  localparam int EVT_W  = $clog2(NUM_EVT),
  localparam int SEM_W  = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  node_addr,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               cfg_we,
  input  logic [EVT_W-1:0]   cfg_evt,
  input  logic [ADDR_W-1:0]  cfg_node,
  input  logic [SEM_W-1:0]   cfg_sem,
  input  logic [UNIT_W-1:0]  cfg_units,
  input  logic               wait_valid,
  input  logic [SEM_W-1:0]   wait_sem,
  input  logic [TASK_W-1:0]  wait_task,
  output logic               wait_ready,
  output logic               grant_valid,
  output logic [SEM_W-1:0]   grant_sem,
  output logic [TASK_W-1:0]  grant_task,
  output logic [NUM_SEM-1:0] sem_ovf,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [ADDR_W-1:0]  msg_node,
  output logic [SEM_W-1:0]   msg_sem,
  output logic [UNIT_W-1:0]  msg_units
);
  logic              sel_valid, take, out_free;
  logic [EVT_W-1:0]  sel_idx;
  logic [ADDR_W-1:0] ent_node;
  logic [SEM_W-1:0]  ent_sem;
  logic [UNIT_W-1:0] ent_units;
  route_e            route;

  esu_evt_detect #(.NUM_EVT(NUM_EVT), .EVT_W(EVT_W)) u_detect (
    .clk(clk), .rst(rst), .evt_in(evt_in), .take(take),
    .sel_valid(sel_valid), .sel_idx(sel_idx)
  );

  esu_cfg_table #(
    .NUM_EVT(NUM_EVT), .EVT_W(EVT_W), .ADDR_W(ADDR_W), .SEM_W(SEM_W), .UNIT_W(UNIT_W)
  ) u_table (
    .clk(clk), .rst(rst), .we(cfg_we), .widx(cfg_evt), .wnode(cfg_node),
    .wsem(cfg_sem), .wunits(cfg_units), .ridx(sel_idx),
    .rnode(ent_node), .rsem(ent_sem), .runits(ent_units)
  );

  assign route    = (ent_node == node_addr) ? ROUTE_LOCAL : ROUTE_REMOTE;
  assign out_free = !msg_valid || msg_ready;
  assign take     = sel_valid && ((route == ROUTE_LOCAL) || out_free);

  esu_sem_bank #(
    .NUM_SEM(NUM_SEM), .SEM_W(SEM_W), .CNT_W(CNT_W), .UNIT_W(UNIT_W),
    .TASK_W(TASK_W), .QDEPTH(QDEPTH)
  ) u_bank (
    .clk(clk), .rst(rst),
    .credit_valid(take && (route == ROUTE_LOCAL)),
    .credit_sem(ent_sem), .credit_units(ent_units),
    .wait_valid(wait_valid), .wait_sem(wait_sem), .wait_task(wait_task),
    .wait_ready(wait_ready), .grant_valid(grant_valid), .grant_sem(grant_sem),
    .grant_task(grant_task), .sem_ovf(sem_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_node  <= '0;
      msg_sem   <= '0;
      msg_units <= '0;
    end else if (take && (route == ROUTE_REMOTE)) begin
      msg_valid <= 1'b1;
      msg_node  <= ent_node;
      msg_sem   <= ent_sem;
      msg_units <= ent_units;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // R7
  msg_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_node)
                                   && $stable(msg_sem) && $stable(msg_units)))
    else $error("outbound message changed while stalled");
endmodule

// File: tb/esu_top_tb.sv
module esu_top_tb;
  localparam int NODE = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] node_addr = 4'(NODE);
  logic [3:0] evt_in = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_evt = '0;
  logic [3:0] cfg_node = '0;
  logic [1:0] cfg_sem = '0;
  logic [3:0] cfg_units = '0;
  logic       wait_valid = 1'b0;
  logic [1:0] wait_sem = '0;
  logic [3:0] wait_task = '0;
  logic       wait_ready, grant_valid, msg_valid;
  logic       msg_ready = 1'b1;
  logic [1:0] grant_sem, msg_sem;
  logic [3:0] grant_task, sem_ovf, msg_node, msg_units;

  always #2.5 clk = ~clk;

  esu_top u_dut (
    .clk(clk), .rst(rst), .node_addr(node_addr), .evt_in(evt_in),
    .cfg_we(cfg_we), .cfg_evt(cfg_evt), .cfg_node(cfg_node), .cfg_sem(cfg_sem),
    .cfg_units(cfg_units), .wait_valid(wait_valid), .wait_sem(wait_sem),
    .wait_task(wait_task), .wait_ready(wait_ready), .grant_valid(grant_valid),
    .grant_sem(grant_sem), .grant_task(grant_task), .sem_ovf(sem_ovf),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_node(msg_node),
    .msg_sem(msg_sem), .msg_units(msg_units)
  );

  int nchk = 0, nbad = 0, cyc = 0;
  int gn = 0, mn = 0;
  int g_task [64], g_sem [64], g_cyc [64];
  int m_node [16], m_sem [16], m_units [16];
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    #1;
    if (grant_valid && gn < 64) begin
      g_task[gn] = int'(grant_task);
      g_sem[gn]  = int'(grant_sem);
      g_cyc[gn]  = cyc;
      gn++;
    end
    if (msg_valid && msg_ready && mn < 16) begin
      m_node[mn]  = int'(msg_node);
      m_sem[mn]   = int'(msg_sem);
      m_units[mn] = int'(msg_units);
      mn++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; evt_in = '0; cfg_we = 1'b0; wait_valid = 1'b0; msg_ready = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(1);
    gn = 0; mn = 0;
  endtask

  task automatic cfg(input int idx, input int node, input int sem, input int units);
    @(negedge clk);
    cfg_we = 1'b1; cfg_evt = 2'(idx); cfg_node = 4'(node);
    cfg_sem = 2'(sem); cfg_units = 4'(units);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] mask);
    @(negedge clk);
    evt_in = mask;
    tick(3);
    evt_in = '0;
    tick(8);
  endtask

  task automatic post_wait(input int sem, input int tk, output bit rdy);
    @(negedge clk);
    wait_valid = 1'b1; wait_sem = 2'(sem); wait_task = 4'(tk);
    #1 rdy = wait_ready;
    @(negedge clk);
    wait_valid = 1'b0;
  endtask

  // sem[11:8], units[7:4], waits[3:0]; units equal waits
  localparam logic [11:0] VEC [6] = '{12'h011, 12'h122, 12'h233, 12'h344, 12'h022, 12'h311};

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    bit rdy;
    do_reset();
    // R1 reset state
    chk(!grant_valid, "R1 grant_valid", int'(grant_valid), 0);
    chk(!msg_valid, "R1 msg_valid", int'(msg_valid), 0);
    chk(sem_ovf == 0, "R1 sem_ovf", int'(sem_ovf), 0);
    chk(wait_ready, "R1 wait_ready", int'(wait_ready), 1);
    post_wait(0, 3, rdy);
    tick(6);
    chk(gn == 0, "R1 no grant from zero count", gn, 0);

    // Vector walk: R2 credit, R4 ordering
    for (int i = 0; i < 6; i++) begin
      int sem = int'(VEC[i][11:8]);
      int un  = int'(VEC[i][7:4]);
      int nw  = int'(VEC[i][3:0]);
      do_reset();
      cfg(i % 4, NODE, sem, un);
      for (int k = 0; k < nw; k++) post_wait(sem, k + 2 * i, rdy);
      tick(4);
      chk(gn == 0, "R4 waits pending without units", gn, 0);
      pulse(4'(1 << (i % 4)));
      chk(gn == nw, "R2 grants after credit", gn, nw);
      for (int k = 0; k < nw && k < gn; k++) begin
        chk(g_task[k] == ((k + 2 * i) & 15), "R4 arrival order", g_task[k], (k + 2 * i) & 15);
        chk(g_sem[k] == sem, "R4 grant_sem", g_sem[k], sem);
        if (k > 0) chk(g_cyc[k] == g_cyc[k-1] + 1, "R4 one per cycle", g_cyc[k] - g_cyc[k-1], 1);
      end
    end

    // R2 held level credits once
    do_reset();
    cfg(1, NODE, 2, 1);
    post_wait(2, 7, rdy);
    post_wait(2, 8, rdy);
    @(negedge clk) evt_in = 4'b0010;
    tick(20);
    chk(gn == 1, "R2 held level single credit", gn, 1);
    evt_in = '0;
    tick(10);
    chk(gn == 1, "R2 falling edge no credit", gn, 1);

    // R5 saturation and sticky flag
    do_reset();
    cfg(1, NODE, 3, 15);
    pulse(4'b0010);
    pulse(4'b0010);
    chk(sem_ovf == 4'b1000, "R5 overflow flag", int'(sem_ovf), 8);
    for (int k = 0; k < 16; k++) post_wait(3, k, rdy);
    tick(6);
    chk(gn == 15, "R5 saturated count", gn, 15);
    chk(sem_ovf == 4'b1000, "R5 flag sticky", int'(sem_ovf), 8);

    // R8 full queue discards the wait
    do_reset();
    for (int k = 1; k <= 4; k++) begin
      post_wait(0, k, rdy);
      chk(rdy, "R8 ready while room", int'(rdy), 1);
    end
    post_wait(0, 5, rdy);
    chk(!rdy, "R8 ready low when full", int'(rdy), 0);
    cfg(0, NODE, 0, 5);
    pulse(4'b0001);
    chk(gn == 4, "R8 four grants", gn, 4);
    post_wait(0, 9, rdy);
    tick(4);
    chk(gn == 5 && g_task[4] == 9, "R8 fifth wait dropped", g_task[4], 9);

    // R9 lowest semaphore wins, R3 index order of simultaneous edges
    do_reset();
    cfg(0, NODE, 2, 2);
    cfg(1, NODE, 1, 1);
    post_wait(2, 5, rdy);
    post_wait(2, 7, rdy);
    post_wait(1, 6, rdy);
    pulse(4'b0011);
    chk(gn == 3, "R9 grant count", gn, 3);
    chk(g_task[0] == 5, "R3 line 0 first", g_task[0], 5);
    chk(g_task[1] == 6, "R9 lowest semaphore wins", g_task[1], 6);
    chk(g_task[2] == 7, "R9 remaining grant", g_task[2], 7);

    // R6 remote credit, R7 stall
    do_reset();
    msg_ready = 1'b0;
    cfg(0, 5, 3, 9);
    post_wait(3, 4, rdy);
    pulse(4'b0001);
    chk(msg_valid, "R6 msg_valid", int'(msg_valid), 1);
    chk(msg_node == 5 && msg_sem == 3 && msg_units == 9, "R6 msg fields",
        int'({msg_node, msg_sem, msg_units}), int'({4'd5, 2'd3, 4'd9}));
    chk(gn == 0, "R6 no local credit", gn, 0);
    cfg(1, 6, 2, 4);
    pulse(4'b0010);
    tick(10);
    chk(msg_valid && msg_node == 5 && msg_units == 9, "R7 stalled message held",
        int'(msg_node), 5);
    @(negedge clk) msg_ready = 1'b1;
    tick(6);
    chk(mn == 2, "R7 both messages sent", mn, 2);
    chk(m_node[0] == 5 && m_sem[0] == 3 && m_units[0] == 9, "R7 first message", m_node[0], 5);
    chk(m_node[1] == 6 && m_sem[1] == 2 && m_units[1] == 4, "R7 second message", m_node[1], 6);
    // R3 simultaneous remote edges in index order
    cfg(2, 7, 1, 2);
    cfg(3, 8, 0, 3);
    mn = 0;
    pulse(4'b1100);
    chk(mn == 2, "R3 two messages", mn, 2);
    chk(m_node[0] == 7 && m_units[0] == 2, "R3 line 2 first", m_node[0], 7);
    chk(m_node[1] == 8 && m_units[1] == 3, "R3 line 3 second", m_node[1], 8);
    chk(gn == 0, "R6 remote never grants", gn, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule